// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with SPI Mode

This block moves one byte at a time over three pins: a serial data output, a serial data input and a clock pin. It is set up through plain configuration inputs. These choose the operating mode, the clock source, the direction of the clock pin and the bit order. A single write pulse loads the byte to send. When the eighth bit has been sampled, the received byte appears on `rx_data`, a sticky completion flag rises and a one-cycle interrupt pulse fires.

The clock source can be internal or external. With the internal clock the block runs its own divided clock for eight full periods. With the external clock it follows the synchronised clock pin and only shifts when that pin moves. In plain synchronous mode the clock idles high, data changes on the falling edge and is sampled on the rising edge, and with the internal clock the data output floats once the byte has finished. SPI-compatible mode adds a programmable idle level and sampling phase. In this mode the internal clock makes the block a master driving MOSI on `sdo`, and the external clock makes it a slave. The slave is gated by an active-low select and drives MISO on `sdo` only while it is selected.

Top module: `sync_serial_port`

## Requirements
- R1: Each transfer is exactly 8 bits. On the sampling of the eighth bit, `rx_data` holds the received byte, `done` goes to 1 and `irq` is high for exactly one clock cycle.
- R2: With `cfg_ext_clk`=0, a write starts a transfer whose clock makes exactly 16 level changes, each lasting HALF_CYC cycles, and ends at its idle level. With `cfg_ext_clk`=1 the block generates no clock and shifts only on edges of `sclk_i`.
- R3: `sclk_oe` is 1 only when `cfg_ext_clk`=0 and `cfg_clk_out`=1. Otherwise the clock pin is an input.
- R4: In plain mode (`cfg_spi`=0) the clock idles high, data changes on the falling edge and is sampled on the rising edge. With the internal clock, `sdo_oe` is 1 during a transfer and 0 after reset and after the byte completes. With the external clock, `sdo_oe` is 1.
- R5: In SPI mode the clock idles at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading edge (the edge leaving idle) and changes on the trailing edge. With `cfg_cpha`=1 it is the other way round. As master, `sdo_oe` stays 1.
- R6: In SPI mode with `cfg_ext_clk`=1 (slave), edges are ignored while `ssel_n`=1 and `sdo_oe` equals NOT `ssel_n`. With `cfg_cpha`=0, the first bit is on `sdo` as soon as the slave is selected, before any clock edge.
- R7: With `cfg_lsb_first`=1, bit 0 is sent first and the first received bit lands in `rx_data[0]`. With `cfg_lsb_first`=0, bit 7 goes first and the first received bit lands in `rx_data[7]`.
- R8: A write clears `done` on the next cycle. A write while an internal-clock transfer is running is ignored, and the running byte finishes unchanged.
- R9: If a write and the eighth sample fall in the same cycle, `irq` still pulses and `rx_data` takes the finished byte. `done` stays 0 and the new byte is armed for the next eight edges.
- R10: After reset, `done`=0, `irq`=0 and `rx_data`=0, and the internal clock sits at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_spi | input | 1 | 1 selects SPI-compatible mode |
| cfg_ext_clk | input | 1 | 0 internal clock, 1 external clock from the pin |
| cfg_clk_out | input | 1 | 1 drives the clock pin when the internal clock is used |
| cfg_lsb_first | input | 1 | 1 sends and receives least significant bit first |
| cfg_cpol | input | 1 | SPI clock idle level |
| cfg_cpha | input | 1 | SPI sampling phase |
| tx_write | input | 1 | One-cycle write of the byte to send |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| sclk_i | input | 1 | Clock pin input value |
| sclk_o | output | 1 | Clock pin output value |
| sclk_oe | output | 1 | Clock pin output enable |
| sdo | output | 1 | Serial data output pin value |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data input pin |
| ssel_n | input | 1 | Active-low slave select |

## Verification
A host write and the sampling of the eighth bit can land in the same cycle. Only the external clock allows this, because internal-clock writes are refused while busy. The bench provokes the case in plain external-clock mode by timing the final rising edge of `sclk_i` so that the synchronised edge reaches the shifter on the same clock as the write pulse. It then checks that exactly one interrupt pulse appeared, that `rx_data` holds the completed byte, that `done` stayed low, and that a further eight edges finish the newly written byte.

// File: rtl/ssp_pkg.sv
// Shared constants and bit-order helpers for the serial port.
// Assumes a fixed byte-wide frame.
package ssp_pkg;
    localparam int BITS = 8;
    typedef logic [BITS-1:0] byte_t;

    // Bit that leaves the shifter first for the chosen order.
    function automatic logic lead_bit(byte_t d, logic lsb);
        return lsb ? d[0] : d[BITS-1];
    endfunction

    // Shift register after one bit has been sent.
    function automatic byte_t advance(byte_t d, logic lsb);
        return lsb ? {1'b0, d[BITS-1:1]} : {d[BITS-2:0], 1'b0};
    endfunction

    // Receive register after one bit has been taken in.
    function automatic byte_t take_in(byte_t r, logic b, logic lsb);
        return lsb ? {b, r[BITS-1:1]} : {r[BITS-2:0], b};
    endfunction
endpackage

// File: rtl/ssp_master_clk.sv
// Internal clock source: on start, produces 16 clock level changes spaced
// HALF_CYC cycles apart, flagging each as leading or trailing.
// Assumes start is only honoured while idle.
module ssp_master_clk #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idle_lvl,
    output logic busy,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);
    localparam int DIV_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int EDGES  = 2 * ssp_pkg::BITS;
    localparam int EDGE_W = $clog2(EDGES);

    logic [DIV_W-1:0]  div;
    logic [EDGE_W-1:0] edge_idx;
    logic              tick;

    // Edge strobes: even-numbered changes leave idle, odd ones return.
    always_comb begin
        tick      = busy && (div == '0);
        lead_stb  = tick && !edge_idx[0];
        trail_stb = tick && edge_idx[0];
    end

    // Divider, edge counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            div      <= '0;
            edge_idx <= '0;
            sclk     <= idle_lvl;
        end else if (!busy) begin
            sclk <= idle_lvl;
            if (start) begin
                busy     <= 1'b1;
                div      <= DIV_W'(HALF_CYC - 1);
                edge_idx <= '0;
            end
        end else if (div == '0) begin
            sclk     <= ~sclk;
            edge_idx <= edge_idx + 1'b1;
            div      <= DIV_W'(HALF_CYC - 1);
            if (edge_idx == EDGE_W'(EDGES - 1)) busy <= 1'b0;
        end else begin
            div <= div - 1'b1;
        end
    end

    // R2: the clock level only moves on a divider expiry.
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div != '0) |=> $stable(sclk));
    // R2: once idle, the clock rests at the idle level.
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(idle_lvl)) |-> (sclk == idle_lvl));
endmodule

// File: rtl/ssp_ext_edge.sv
// External clock front end: two-flop synchroniser plus a history flop;
// classifies each pin change as leading (leaves idle) or trailing.
// Assumes the pin is slower than a few system cycles per level.
module ssp_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic idle_lvl,
    output logic lead_stb,
    output logic trail_stb
);
    logic s1, s2, s3;

    // Synchronise the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= idle_lvl;
            s2 <= idle_lvl;
            s3 <= idle_lvl;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Edge classification against the idle level.
    always_comb begin
        lead_stb  = (s2 != s3) && (s2 != idle_lvl);
        trail_stb = (s2 != s3) && (s2 == idle_lvl);
    end
endmodule

// File: rtl/ssp_shift.sv
// Shift engine: maps leading/trailing strobes to sample and drive events
// by phase, shifts in the chosen order and reports completion.
// Assumes sample and drive strobes are never both active.
module ssp_shift
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  lsb_first,
    input  logic  cpha,
    input  logic  lead_stb,
    input  logic  trail_stb,
    input  logic  sdi,
    output logic  sdo_bit,
    output byte_t rx_data,
    output logic  done,
    output logic  irq
);
    localparam int CNT_W = $clog2(BITS + 1);

    byte_t             tx_sr;
    logic [CNT_W-1:0]  bitcnt;
    logic              sample_stb;
    logic              drive_stb;
    logic              active;

    // Phase selects which edge samples and which edge drives.
    always_comb begin
        sample_stb = cpha ? trail_stb : lead_stb;
        drive_stb  = cpha ? lead_stb  : trail_stb;
        active     = bitcnt < CNT_W'(BITS);
    end

    // Shift, count and completion; a load takes priority over count and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            sdo_bit <= 1'b0;
            rx_data <= '0;
            bitcnt  <= CNT_W'(BITS);
            done    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (sample_stb && active) begin
                rx_data <= take_in(rx_data, sdi, lsb_first);
                bitcnt  <= bitcnt + 1'b1;
                if (bitcnt == CNT_W'(BITS - 1)) begin
                    done <= 1'b1;
                    irq  <= 1'b1;
                end
            end
            if (drive_stb && active) begin
                sdo_bit <= lead_bit(tx_sr, lsb_first);
                tx_sr   <= advance(tx_sr, lsb_first);
            end
            if (load) begin
                bitcnt <= '0;
                done   <= 1'b0;
                if (!cpha) begin
                    sdo_bit <= lead_bit(load_data, lsb_first);
                    tx_sr   <= advance(load_data, lsb_first);
                end else begin
                    tx_sr <= load_data;
                end
            end
        end
    end

    // R1: the interrupt is a single-cycle pulse.
    a_r1_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R1: the flag never rises without the pulse.
    a_r1_done_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq);
    // R8: a load clears the flag.
    a_r8_load_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
endmodule

// File: rtl/sync_serial_port.sv
// Top: byte-wide clock-synchronous serial port with plain and SPI modes.
// Picks the clock source, gates slave edges with the select, and drives
// the pin enables. Assumes configuration is held stable during a byte.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_spi,
    input  logic        cfg_ext_clk,
    input  logic        cfg_clk_out,
    input  logic        cfg_lsb_first,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        tx_write,
    input  logic [7:0]  tx_data,
    output logic [7:0]  rx_data,
    output logic        done,
    output logic        irq,
    input  logic        sclk_i,
    output logic        sclk_o,
    output logic        sclk_oe,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        sdi,
    input  logic        ssel_n
);
    logic eff_cpol, eff_cpha;
    logic m_busy, m_sclk, m_lead, m_trail, m_start;
    logic e_lead, e_trail, ext_gate;
    logic lead, trail, load;

    // Plain mode behaves as idle-high, sample-on-return.
    always_comb begin
        eff_cpol = cfg_spi ? cfg_cpol : 1'b1;
        eff_cpha = cfg_spi ? cfg_cpha : 1'b1;
        m_start  = tx_write && !cfg_ext_clk && !m_busy;
        load     = tx_write && (cfg_ext_clk || !m_busy);
        ext_gate = !(cfg_spi && ssel_n);
        lead     = cfg_ext_clk ? (e_lead && ext_gate)  : m_lead;
        trail    = cfg_ext_clk ? (e_trail && ext_gate) : m_trail;
    end

    ssp_master_clk #(.HALF_CYC(HALF_CYC)) i_mclk (
        .clk(clk), .rst_n(rst_n), .start(m_start), .idle_lvl(eff_cpol),
        .busy(m_busy), .sclk(m_sclk), .lead_stb(m_lead), .trail_stb(m_trail)
    );

    ssp_ext_edge i_eedge (
        .clk(clk), .rst_n(rst_n), .pin(sclk_i), .idle_lvl(eff_cpol),
        .lead_stb(e_lead), .trail_stb(e_trail)
    );

    ssp_shift i_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_data),
        .lsb_first(cfg_lsb_first), .cpha(eff_cpha), .lead_stb(lead),
        .trail_stb(trail), .sdi(sdi), .sdo_bit(sdo), .rx_data(rx_data),
        .done(done), .irq(irq)
    );

    // Pin drivers: clock direction and data output enable per mode.
    always_comb begin
        sclk_o  = m_sclk;
        sclk_oe = !cfg_ext_clk && cfg_clk_out;
        if (cfg_spi) sdo_oe = cfg_ext_clk ? !ssel_n : 1'b1;
        else         sdo_oe = cfg_ext_clk ? 1'b1 : m_busy;
    end

    // R4: plain internal-clock output floats when the byte completes.
    a_r4_float_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_spi && !cfg_ext_clk && $rose(done)) |-> !sdo_oe);
    // R6: an unselected slave takes in nothing.
    a_r6_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_spi && cfg_ext_clk && ssel_n) |=> $stable(rx_data));
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
    import ssp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic cfg_spi = 0, cfg_ext_clk = 0, cfg_clk_out = 1, cfg_lsb_first = 0;
    logic cfg_cpol = 0, cfg_cpha = 0, tx_write = 0, sclk_i = 1, ssel_n = 1;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic done, irq, sclk_o, sclk_oe, sdo, sdo_oe, sdi;
    logic m_sdi = 0, t_sdi = 0, model_on = 0;

    assign sdi = model_on ? m_sdi : t_sdi;

    sync_serial_port i_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .cfg_spi(cfg_spi), .cfg_ext_clk(cfg_ext_clk),
        .cfg_clk_out(cfg_clk_out), .cfg_lsb_first(cfg_lsb_first),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .tx_write(tx_write),
        .tx_data(tx_data), .rx_data(rx_data), .done(done), .irq(irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdo(sdo),
        .sdo_oe(sdo_oe), .sdi(sdi), .ssel_n(ssel_n)
    );

    int n_tests = 0, n_fail = 0;
    int irq_cnt = 0, irq_wide = 0;
    logic irq_prev = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic byte_t rev8(byte_t d);
        byte_t r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    // Count interrupt pulses and any that last longer than one cycle.
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (irq && irq_prev) irq_wide++;
        irq_prev = irq;
    end

    // Remote device model for master transfers.
    logic m_prev = 0, m_idle = 0, m_cpha = 0;
    byte_t m_cap = '0, m_seq = '0;
    int m_ncap = 0, m_edges = 0, m_si = 0;
    always @(negedge clk) begin : remote
        logic is_lead;
        if (model_on && (sclk_o !== m_prev)) begin
            m_edges++;
            is_lead = (sclk_o != m_idle);
            if (is_lead ^ m_cpha) begin
                m_cap = {m_cap[6:0], sdo};
                m_ncap++;
            end else if (m_si < 8) begin
                m_sdi = m_seq[7-m_si];
                m_si++;
            end
            m_prev = sclk_o;
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        finish_run();
    end

    task automatic pulse_write(input byte_t d);
        tx_data = d;
        tx_write = 1;
        @(negedge clk);
        tx_write = 0;
    endtask

    // R10 / R4: state straight after reset, plain internal-clock setup.
    task automatic t_reset_state();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done == 0, "R10", "done after reset", int'(done), 0);
        chk(irq == 0, "R10", "irq after reset", int'(irq), 0);
        chk(rx_data == 0, "R10", "rx_data after reset", int'(rx_data), 0);
        chk(sclk_o == 1, "R10", "idle clock after reset", int'(sclk_o), 1);
        chk(sdo_oe == 0, "R4", "data output floats after reset", int'(sdo_oe), 0);
    endtask

    // R3: clock pin direction.
    task automatic t_clock_dir();
        cfg_ext_clk = 0; cfg_clk_out = 0; @(negedge clk);
        chk(sclk_oe == 0, "R3", "internal clock, pin input", int'(sclk_oe), 0);
        cfg_clk_out = 1; @(negedge clk);
        chk(sclk_oe == 1, "R3", "internal clock, pin output", int'(sclk_oe), 1);
        cfg_ext_clk = 1; @(negedge clk);
        chk(sclk_oe == 0, "R3", "external clock, pin input", int'(sclk_oe), 0);
        cfg_ext_clk = 0; @(negedge clk);
    endtask

    // R1 R2 R4 R5 R7 R8: one internal-clock transfer against the remote model.
    task automatic t_master(input bit spi, input bit cpol, input bit cpha,
                            input bit lsb, input byte_t tx, input byte_t pat,
                            input bit poke);
        bit ec, ep;
        byte_t exp_cap;
        cfg_spi = spi; cfg_ext_clk = 0; cfg_clk_out = 1;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        ec = spi ? cpol : 1'b1;
        ep = spi ? cpha : 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk_o == ec, spi ? "R5" : "R4", "idle clock level", int'(sclk_o), int'(ec));
        m_idle = ec; m_cpha = ep; m_prev = sclk_o;
        m_cap = '0; m_ncap = 0; m_edges = 0;
        m_seq = lsb ? rev8(pat) : pat;
        if (!ep) begin m_sdi = m_seq[7]; m_si = 1; end
        else m_si = 0;
        model_on = 1;
        irq_cnt = 0; irq_wide = 0;
        pulse_write(tx);
        @(negedge clk);
        chk(done == 0, "R8", "write clears done", int'(done), 0);
        repeat (18) @(negedge clk);
        chk(sdo_oe == 1, "R4", "output driven mid-transfer", int'(sdo_oe), 1);
        if (poke) pulse_write(~tx);
        repeat (60) @(negedge clk);
        model_on = 0;
        exp_cap = lsb ? rev8(tx) : tx;
        chk(done == 1, "R1", "done after byte", int'(done), 1);
        chk(irq_cnt == 1, "R1", "irq pulse count", irq_cnt, 1);
        chk(irq_wide == 0, "R1", "irq width", irq_wide, 0);
        chk(rx_data == pat, "R7", "received byte", int'(rx_data), int'(pat));
        chk(m_cap == exp_cap, poke ? "R8" : "R7", "bits sent in time order",
            int'(m_cap), int'(exp_cap));
        chk(m_ncap == 8, "R5", "samples on the sampling edge", m_ncap, 8);
        chk(m_edges == 16, "R2", "clock level changes", m_edges, 16);
        chk(sclk_o == ec, "R2", "clock back at idle", int'(sclk_o), int'(ec));
        chk(sdo_oe == spi, spi ? "R5" : "R4", "output enable after byte",
            int'(sdo_oe), int'(spi));
    endtask

    // R6 R5 R7 R2: slave transfer driven by the bench as external master.
    task automatic t_slave(input bit cpol, input bit cpha, input bit lsb,
                           input byte_t tx, input byte_t pat);
        byte_t seq, cap, exp_cap;
        cfg_spi = 1; cfg_ext_clk = 1; cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_lsb_first = lsb; sclk_i = cpol; ssel_n = 1;
        repeat (4) @(negedge clk);
        pulse_write(tx);
        repeat (3) @(negedge clk);
        chk(sdo_oe == 0, "R6", "unselected slave floats", int'(sdo_oe), 0);
        chk(sclk_oe == 0, "R2", "slave drives no clock", int'(sclk_oe), 0);
        ssel_n = 0;
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1, "R6", "selected slave drives", int'(sdo_oe), 1);
        if (!cpha)
            chk(sdo == (lsb ? tx[0] : tx[7]), "R6", "first bit before first edge",
                int'(sdo), int'(lsb ? tx[0] : tx[7]));
        seq = lsb ? rev8(pat) : pat;
        cap = '0;
        irq_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (!cpha) begin
                t_sdi = seq[7-i];
                cap = {cap[6:0], sdo};
                sclk_i = ~cpol; repeat (4) @(negedge clk);
                sclk_i = cpol;  repeat (4) @(negedge clk);
            end else begin
                sclk_i = ~cpol; repeat (4) @(negedge clk);
                cap = {cap[6:0], sdo};
                t_sdi = seq[7-i];
                sclk_i = cpol;  repeat (4) @(negedge clk);
            end
        end
        exp_cap = lsb ? rev8(tx) : tx;
        chk(done == 1, "R1", "slave done", int'(done), 1);
        chk(irq_cnt == 1, "R1", "slave irq count", irq_cnt, 1);
        chk(rx_data == pat, "R7", "slave received byte", int'(rx_data), int'(pat));
        chk(cap == exp_cap, "R5", "slave bits in time order", int'(cap), int'(exp_cap));
        // R6: edges while deselected are ignored.
        ssel_n = 1;
        pulse_write(8'h3C);
        for (int i = 0; i < 8; i++) begin
            t_sdi = ~t_sdi;
            sclk_i = ~cpol; repeat (4) @(negedge clk);
            sclk_i = cpol;  repeat (4) @(negedge clk);
        end
        chk(done == 0, "R6", "no byte while deselected", int'(done), 0);
        chk(rx_data == pat, "R6", "rx held while deselected", int'(rx_data), int'(pat));
    endtask

    // R9 R4 R2: write lands in the same cycle as the eighth sample.
    task automatic t_collision(input byte_t pat, input byte_t pat2);
        cfg_spi = 0; cfg_ext_clk = 1; cfg_lsb_first = 0;
        sclk_i = 1;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1, "R4", "plain external clock drives output", int'(sdo_oe), 1);
        pulse_write(8'h96);
        irq_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            sclk_i = 0; repeat (4) @(negedge clk);
            t_sdi = pat[7-i];
            sclk_i = 1;
            if (i < 7) repeat (4) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        pulse_write(8'h5A);
        repeat (3) @(negedge clk);
        chk(irq_cnt == 1, "R9", "irq on coincident write", irq_cnt, 1);
        chk(rx_data == pat, "R9", "finished byte kept", int'(rx_data), int'(pat));
        chk(done == 0, "R9", "write wins over flag", int'(done), 0);
        for (int i = 0; i < 8; i++) begin
            sclk_i = 0; repeat (4) @(negedge clk);
            t_sdi = pat2[7-i];
            sclk_i = 1; repeat (4) @(negedge clk);
        end
        chk(done == 1, "R9", "armed byte completes", int'(done), 1);
        chk(irq_cnt == 2, "R2", "external edges finish second byte", irq_cnt, 2);
        chk(rx_data == pat2, "R9", "second byte received", int'(rx_data), int'(pat2));
    endtask

    initial begin
        t_reset_state();
        t_clock_dir();
        t_master(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
        t_master(1'b0, 1'b0, 1'b0, 1'b1, 8'h1E, 8'hC1, 1'b0);
        t_master(1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E, 1'b0);
        t_master(1'b1, 1'b0, 1'b1, 1'b1, 8'h4D, 8'hB2, 1'b0);
        t_master(1'b1, 1'b1, 1'b0, 1'b1, 8'hE7, 8'h18, 1'b0);
        t_master(1'b1, 1'b1, 1'b1, 1'b0, 8'h69, 8'h0F, 1'b1);
        t_slave(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5B);
        t_slave(1'b1, 1'b1, 1'b1, 8'h2E, 8'hD4);
        t_collision(8'hB7, 8'h4E);
        finish_run();
    end
endmodule